// File: doc/BRIEF.md
# DMA Burst Address Sequencer

This block runs one DMA descriptor. A start strobe captures its settings: start source address, start target address, byte length, a step-enable bit for each side, a pacing bit for each side, a burst-size code, a memory-or-peripheral flag for each side, a byte-addressing enable and a width field. The block then offers one burst at a time. Each burst carries the source address, the target address and the byte count. The bus side accepts a burst with `burst_ack`.

On a paced side, a burst is offered only while that side's peripheral holds its request line high. After each accepted burst:
- the remaining length drops by the bytes moved;
- each side with stepping enabled advances by the same amount.

The block pulses `done` in the cycle after the last burst and returns to idle. If both sides are memory and the width field is not zero, the block pulses `err` and does not start.

Top module: `burst_seq`

## Requirements
- R1: Unless `align_en` is set, every address the block drives for a memory side (`*_is_ext`=1) has bits [2:0] forced to zero.
- R2: Unless `align_en` is set, every address the block drives for a peripheral side (`*_is_ext`=0) has bits [1:0] forced to zero.
- R3: With `align_en`=1, the captured addresses are driven out unchanged, so any byte address can be used.
- R4: `burst_size` 00 selects 8 bytes, 01 selects 16 bytes, and 10 or 11 selects 32 bytes. `burst_bytes` equals the burst size, or the remaining length when that is smaller.
- R5: After an accepted burst, the source address advances by `burst_bytes` only when `src_inc`=1, and the target address advances only when `dst_inc`=1. A side with stepping disabled keeps its address.
- R6: With `src_flow`=1, no burst is offered while `src_req`=0. With `dst_flow`=1, no burst is offered while `dst_req`=0.
- R7: When both sides are memory and `width` is not 00, a start produces a one-cycle `err` pulse in the next cycle. No burst is issued and `busy` stays low.
- R8: `remaining` decreases by `burst_bytes` on every accepted burst.
- R9: After the final accepted burst, `done` is high for exactly one cycle, in the next cycle, and `busy` is low in that same cycle.
- R10: A start with length zero gives a `done` pulse in the next cycle and issues no burst.
- R11: A `start` pulse that arrives while `busy`=1 is ignored. The running transfer keeps its addresses and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, honoured only when idle |
| src_addr | input | AW | Start source address |
| dst_addr | input | AW | Start target address |
| len | input | LW | Transfer length in bytes |
| src_inc | input | 1 | Advance the source address after each burst |
| dst_inc | input | 1 | Advance the target address after each burst |
| src_flow | input | 1 | Pace bursts on `src_req` |
| dst_flow | input | 1 | Pace bursts on `dst_req` |
| burst_size | input | 2 | Burst size code (00=8, 01=16, else 32 bytes) |
| src_is_ext | input | 1 | Source is memory (1) or a peripheral (0) |
| dst_is_ext | input | 1 | Target is memory (1) or a peripheral (0) |
| align_en | input | 1 | Drive byte addresses without truncation |
| width | input | 2 | Width field, must be 00 for memory-to-memory |
| src_req | input | 1 | Source peripheral request |
| dst_req | input | 1 | Target peripheral request |
| burst_ack | input | 1 | Bus side accepts the offered burst |
| busy | output | 1 | Transfer in progress |
| burst_valid | output | 1 | A burst is offered |
| burst_src | output | AW | Source address of the offered burst |
| burst_dst | output | AW | Target address of the offered burst |
| burst_bytes | output | 6 | Byte count of the offered burst |
| remaining | output | LW | Bytes left to move |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle width error pulse |

## Verification
The directed transfers are chosen to separate different faults:
- A memory-to-memory copy whose length is not a multiple of the burst size shows whether the last burst is shortened to the remainder and whether both addresses advance.
- Unaligned start addresses, run once with `align_en` low and once high, separate the three-bit and two-bit truncation from the pass-through.
- A peripheral-to-memory read with the request line held low, then raised, shows both pacing and a fixed peripheral address next to a stepping memory address.
- Zero length, a bad width and a second start during a stalled transfer each check that the block either refuses to start or ignores the second strobe.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [LW-1:0] len,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic          src_flow,
  input  logic          dst_flow,
  input  logic [1:0]    burst_size,
  input  logic          src_is_ext,
  input  logic          dst_is_ext,
  input  logic          align_en,
  input  logic [1:0]    width,
  input  logic          src_req,
  input  logic          dst_req,
  input  logic          burst_ack,
  output logic          busy,
  output logic          burst_valid,
  output logic [AW-1:0] burst_src,
  output logic [AW-1:0] burst_dst,
  output logic [5:0]    burst_bytes,
  output logic [LW-1:0] remaining,
  output logic          done,
  output logic          err
);
  localparam int BW = 6;

  logic [AW-1:0] s_addr, d_addr;
  logic [LW-1:0] rem;
  logic [BW-1:0] bsz;
  logic s_inc, d_inc, s_flw, d_flw, s_ext, d_ext, aln;
  logic busy_q, done_q, err_q;

  function automatic logic [BW-1:0] size_of(input logic [1:0] code);
    case (code)
      2'b00:   size_of = BW'(8);
      2'b01:   size_of = BW'(16);
      default: size_of = BW'(32);
    endcase
  endfunction

  function automatic logic [AW-1:0] shape(input logic [AW-1:0] a, input logic ext, input logic pass);
    if (pass)     shape = a;
    else if (ext) shape = a & ~AW'(7);
    else          shape = a & ~AW'(3);
  endfunction

  wire bad_width = src_is_ext & dst_is_ext & (width != 2'b00);
  wire [LW-1:0] bsz_l = LW'(bsz);
  wire [LW-1:0] step  = (rem < bsz_l) ? rem : bsz_l;
  wire go   = busy_q & (~s_flw | src_req) & (~d_flw | dst_req);
  wire fire = go & burst_ack;
  wire last = fire & (rem == step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_addr <= '0;
      d_addr <= '0;
      rem    <= '0;
      bsz    <= BW'(8);
      s_inc  <= 1'b0;
      d_inc  <= 1'b0;
      s_flw  <= 1'b0;
      d_flw  <= 1'b0;
      s_ext  <= 1'b0;
      d_ext  <= 1'b0;
      aln    <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q && start) begin
        if (bad_width) begin
          err_q <= 1'b1;
        end else if (len == '0) begin
          done_q <= 1'b1;
        end else begin
          s_addr <= src_addr;
          d_addr <= dst_addr;
          rem    <= len;
          bsz    <= size_of(burst_size);
          s_inc  <= src_inc;
          d_inc  <= dst_inc;
          s_flw  <= src_flow;
          d_flw  <= dst_flow;
          s_ext  <= src_is_ext;
          d_ext  <= dst_is_ext;
          aln    <= align_en;
          busy_q <= 1'b1;
        end
      end else if (fire) begin
        rem <= rem - step;
        if (s_inc) s_addr <= s_addr + AW'(step);
        if (d_inc) d_addr <= d_addr + AW'(step);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign err         = err_q;
  assign burst_valid = go;
  assign burst_src   = shape(s_addr, s_ext, aln);
  assign burst_dst   = shape(d_addr, d_ext, aln);
  assign burst_bytes = step[BW-1:0];
  assign remaining   = rem;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          burst_valid,
  input logic          burst_ack,
  input logic [AW-1:0] burst_src,
  input logic [AW-1:0] burst_dst,
  input logic [5:0]    burst_bytes,
  input logic [LW-1:0] remaining,
  input logic          done,
  input logic          err,
  input logic          s_ext,
  input logic          d_ext,
  input logic          aln,
  input logic          s_inc,
  input logic          d_inc,
  input logic          s_flw,
  input logic          d_flw,
  input logic          src_req,
  input logic          dst_req
);
  // R1
  ext_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !aln |-> (!s_ext || burst_src[2:0] == 3'b0) && (!d_ext || burst_dst[2:0] == 3'b0));

  // R2
  per_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !aln |-> (s_ext || burst_src[1:0] == 2'b0) && (d_ext || burst_dst[1:0] == 2'b0));

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> burst_bytes != 6'd0 && burst_bytes <= 6'd32 && LW'(burst_bytes) <= remaining);

  // R5
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && burst_ack && !s_inc |=> $stable(burst_src));

  // R5
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && burst_ack && !d_inc |=> $stable(burst_dst));

  // R6
  pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_flw && !src_req) || (d_flw && !dst_req) |-> !burst_valid);

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !burst_valid && !done);

  // R8
  rem_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && burst_ack && LW'(burst_bytes) < remaining |=>
      remaining == $past(remaining) - LW'($past(burst_bytes)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind burst_seq burst_seq_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .burst_valid(burst_valid),
  .burst_ack(burst_ack), .burst_src(burst_src), .burst_dst(burst_dst),
  .burst_bytes(burst_bytes), .remaining(remaining), .done(done), .err(err),
  .s_ext(s_ext), .d_ext(d_ext), .aln(aln), .s_inc(s_inc), .d_inc(d_inc),
  .s_flw(s_flw), .d_flw(d_flw), .src_req(src_req), .dst_req(dst_req)
);

// File: tb/sim_burst_seq.sv
module sim_burst_seq;
  localparam int AW = 32;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0;
  logic [LW-1:0] len = '0;
  logic src_inc = 0, dst_inc = 0, src_flow = 0, dst_flow = 0;
  logic [1:0] burst_size = 2'b00, width = 2'b00;
  logic src_is_ext = 1, dst_is_ext = 1, align_en = 0;
  logic src_req = 0, dst_req = 0, burst_ack = 0;
  logic busy, burst_valid, done, err;
  logic [AW-1:0] burst_src, burst_dst;
  logic [5:0] burst_bytes;
  logic [LW-1:0] remaining;

  int checks = 0, errors = 0;
  int nb = 0, done_cnt = 0, err_cnt = 0;
  logic [AW-1:0] rs [0:15];
  logic [AW-1:0] rd [0:15];
  logic [5:0]    rb [0:15];
  logic [LW-1:0] rr [0:15];

  always #2 clk = ~clk;

  burst_seq #(.AW(AW), .LW(LW)) u0 (.*);

  always @(negedge clk) begin
    if (burst_valid && burst_ack && nb < 16) begin
      rs[nb] = burst_src; rd[nb] = burst_dst; rb[nb] = burst_bytes; rr[nb] = remaining;
      nb = nb + 1;
    end
    if (done) done_cnt = done_cnt + 1;
    if (err) err_cnt = err_cnt + 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [LW-1:0] l,
                       input logic si, input logic di, input logic sf, input logic df,
                       input logic [1:0] bs, input logic se, input logic de, input logic al,
                       input logic [1:0] w);
    src_addr = s; dst_addr = d; len = l; src_inc = si; dst_inc = di;
    src_flow = sf; dst_flow = df; burst_size = bs; src_is_ext = se; dst_is_ext = de;
    align_en = al; width = w;
  endtask

  task automatic kick();
    nb = 0; done_cnt = 0; err_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_xfer();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R7 reset err", err, 0);
    chk("R6 reset valid", burst_valid, 0);
  endtask

  task automatic t_copy();
    burst_ack = 1;
    setup(32'h1000, 32'h2000, 20, 1, 1, 0, 0, 2'b00, 1, 1, 0, 2'b00);
    kick();
    finish_xfer();
    chk("R4 copy count", nb, 3);
    chk("R5 copy src0", rs[0], 32'h1000);
    chk("R5 copy src1", rs[1], 32'h1008);
    chk("R5 copy dst2", rd[2], 32'h2010);
    chk("R4 copy bytes0", rb[0], 8);
    chk("R4 copy tail bytes", rb[2], 4);
    chk("R8 copy rem1", rr[1], 12);
    chk("R8 copy rem2", rr[2], 4);
    chk("R9 copy done once", done_cnt, 1);
    chk("R9 copy idle", busy, 0);
  endtask

  task automatic t_trunc();
    burst_ack = 1; dst_req = 1;
    setup(32'h1005, 32'h3007, 16, 1, 0, 0, 1, 2'b01, 1, 0, 0, 2'b00);
    kick();
    finish_xfer();
    chk("R1 trunc count", nb, 1);
    chk("R1 memory side", rs[0], 32'h1000);
    chk("R2 peripheral side", rd[0], 32'h3004);
    chk("R4 size 16", rb[0], 16);
    dst_req = 0;
  endtask

  task automatic t_pass();
    burst_ack = 1; dst_req = 1;
    setup(32'h1005, 32'h3007, 16, 1, 0, 0, 1, 2'b01, 1, 0, 1, 2'b00);
    kick();
    finish_xfer();
    chk("R3 pass src", rs[0], 32'h1005);
    chk("R3 pass dst", rd[0], 32'h3007);
    dst_req = 0;
  endtask

  task automatic t_pace();
    burst_ack = 1; src_req = 0;
    setup(32'h4000, 32'h5000, 40, 0, 1, 1, 0, 2'b10, 0, 1, 0, 2'b00);
    kick();
    repeat (5) @(negedge clk);
    chk("R6 stalled valid", burst_valid, 0);
    chk("R6 stalled count", nb, 0);
    chk("R6 stalled busy", busy, 1);
    src_req = 1;
    finish_xfer();
    chk("R6 paced count", nb, 2);
    chk("R5 fixed src", rs[1], 32'h4000);
    chk("R5 stepping dst", rd[1], 32'h5020);
    chk("R4 size 32", rb[0], 32);
    chk("R4 tail 8", rb[1], 8);
    src_req = 0;
  endtask

  task automatic t_width();
    burst_ack = 1;
    setup(32'h1000, 32'h2000, 16, 1, 1, 0, 0, 2'b00, 1, 1, 0, 2'b01);
    kick();
    chk("R7 err pulse", err, 1);
    chk("R7 busy low", busy, 0);
    repeat (3) @(negedge clk);
    chk("R7 err once", err_cnt, 1);
    chk("R7 no bursts", nb, 0);
    chk("R7 no done", done_cnt, 0);
    width = 2'b00;
  endtask

  task automatic t_zero();
    burst_ack = 1;
    setup(32'h1000, 32'h2000, 0, 1, 1, 0, 0, 2'b00, 1, 1, 0, 2'b00);
    kick();
    chk("R10 done next cycle", done, 1);
    chk("R10 busy low", busy, 0);
    repeat (3) @(negedge clk);
    chk("R10 no bursts", nb, 0);
    chk("R10 done once", done_cnt, 1);
  endtask

  task automatic t_restart();
    burst_ack = 0;
    setup(32'h6000, 32'h7000, 16, 1, 1, 0, 0, 2'b00, 1, 1, 0, 2'b00);
    kick();
    setup(32'h8000, 32'h9000, 64, 1, 1, 0, 0, 2'b10, 1, 1, 0, 2'b00);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 src kept", burst_src, 32'h6000);
    chk("R11 rem kept", remaining, 16);
    burst_ack = 1;
    finish_xfer();
    chk("R11 count", nb, 2);
    chk("R11 second src", rs[1], 32'h6008);
    chk("R11 done once", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_copy();
    t_trunc();
    t_pass();
    t_pace();
    t_width();
    t_zero();
    t_restart();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule